// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading translation descriptors from memory. A caller presents a virtual address together with the translation table base. The walker builds the address of the first-level entry and reads one 32-bit word through a simple valid/ready request port with a separate response strobe. It then classifies that word by its two low bits. The word is a fault, a 1 MB section mapping, or a pointer to a second-level table. A second-level table is either coarse (256 entries of 4 KB) or fine (1024 entries of 1 KB).

A section finishes the walk after one read. A table pointer leads to a second read at an address built from the table base and the middle bits of the virtual address. The final result is a physical address, a domain, access-permission bits, cacheable and bufferable flags and a fault code. It is announced with a one-cycle completion pulse. TLB storage, domain and permission checks and cache control belong to the surrounding logic.

Top module: `tablewalk_unit`

## Requirements
- R1: Out of reset `req_ready` is 1 and `mem_req_valid` and `done` are 0. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle, and `req_valid`, `req_vaddr` and `req_ttb` have no effect while it is busy.
- R2: The first memory read goes to {`req_ttb`[31:14], `req_vaddr`[31:20], 2'b00}. Bits [13:0] of `req_ttb` are ignored.
- R3: Once raised, `mem_req_valid` stays high with an unchanged `mem_req_addr` until a cycle in which `mem_req_ready` is high. Exactly one read is issued per handshake, and no request is raised while a read is outstanding.
- R4: A first-level word with bits [1:0] = 00 ends the walk with `res_fault` = 1. No second read is issued, and `res_paddr`, `res_domain`, `res_ap`, `res_cacheable` and `res_bufferable` are all 0.
- R5: A first-level word with bits [1:0] = 10 (section) ends the walk after that single read with `res_fault` = 0. The other results are: `res_paddr` = {word[31:20], va[19:0]}, `res_ap` = word[11:10], `res_domain` = word[8:5], `res_cacheable` = word[3] and `res_bufferable` = word[2].
- R6: A first-level word with bits [1:0] = 01 (coarse table) leads to a second read at {word[31:10], va[19:12], 2'b00}.
- R7: A first-level word with bits [1:0] = 11 (fine table) leads to a second read at {word[31:12], va[19:10], 2'b00}.
- R8: A second-level word with bits [1:0] = 00 ends the walk with `res_fault` = 2. `res_domain` is the first-level word's bits [8:5], and the address, permission and C/B results are 0.
- R9: After a coarse table, a second-level word with nonzero bits [1:0] gives a 4 KB page with `res_fault` = 0. The results are: `res_paddr` = {word[31:12], va[11:0]}, `res_ap` = word[5:4], C = word[3], B = word[2], and the domain comes from the first-level word.
- R10: After a fine table, a second-level word with nonzero bits [1:0] gives a 1 KB page with `res_paddr` = {word[31:10], va[9:0]}. The other fields follow the same rules as R9.
- R11: `done` is high for exactly one cycle per accepted request, the result outputs are valid in that cycle, and `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Translation table base (bits [31:14] used) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Word address of the descriptor read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word returned |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | 32 | Translated physical address |
| res_domain | output | 4 | Domain of the mapping |
| res_ap | output | 2 | Access-permission bits |
| res_cacheable | output | 1 | Cacheable flag |
| res_bufferable | output | 1 | Bufferable flag |
| res_fault | output | 2 | 0 no fault, 1 first-level fault, 2 second-level fault |

## Verification
A walker stuck in a wrong state shows up within one cycle. It appears as a read strobe in the wrong phase, a missing or doubled `done`, or `req_ready` asserted while a walk is still in flight. A corrupted latched address or table kind first shows on `mem_req_addr` when the second read is raised. A bad latched domain or a bad decode shows only at the `done` pulse, in the result fields. The bench therefore compares every port against a behavioural model on every clock, with random memory back-pressure and latency. It also drives random requests while the walker is busy, so that ignored inputs that leak in are caught.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } tw_state_e;

   // descriptor kind taken from word bits [1:0]
   typedef enum logic [1:0] {
      DK_FAULT   = 2'b00,
      DK_COARSE  = 2'b01,
      DK_SECTION = 2'b10,
      DK_FINE    = 2'b11
   } tw_kind_e;

   localparam int FLT_W = 2;
   localparam logic [FLT_W-1:0] FLT_NONE = 2'd0;
   localparam logic [FLT_W-1:0] FLT_L1   = 2'd1;
   localparam logic [FLT_W-1:0] FLT_L2   = 2'd2;

   // field layout inside descriptor words
   localparam int DOM_W     = 4;
   localparam int DOM_LO    = 5;
   localparam int AP_W      = 2;
   localparam int SEC_AP_LO = 10;
   localparam int PG_AP_LO  = 4;
   localparam int C_POS     = 3;
   localparam int B_POS     = 2;

endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
   import tw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEC_LO     = 20,
   parameter int LG_PAGE_LO = 12,
   parameter int SM_PAGE_LO = 10
) (
   input  logic [ADDR_W-1:0] ttb,
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] desc,
   input  logic              fine_tbl,
   output logic [ADDR_W-1:0] l1_addr,
   output logic [ADDR_W-1:0] l2_addr
);
   localparam int IDX1_W   = ADDR_W - SEC_LO;
   localparam int TTB_LO   = IDX1_W + 2;
   localparam int CIDX_W   = SEC_LO - LG_PAGE_LO;
   localparam int CBASE_LO = CIDX_W + 2;
   localparam int FIDX_W   = SEC_LO - SM_PAGE_LO;
   localparam int FBASE_LO = FIDX_W + 2;

   generate
      if (ADDR_W != 32)
         $error("tw_addr_gen: descriptors are 32-bit words, ADDR_W must be 32");
      if (!(SM_PAGE_LO < LG_PAGE_LO && LG_PAGE_LO < SEC_LO))
         $error("tw_addr_gen: page sizes must nest inside the section size");
      if (TTB_LO >= ADDR_W)
         $error("tw_addr_gen: table index leaves no base bits");
      if (CBASE_LO <= DOM_LO + DOM_W - 1 || FBASE_LO <= DOM_LO + DOM_W - 1)
         $error("tw_addr_gen: table base overlaps the domain field");
   endgenerate

   logic [ADDR_W-1:0] coarse_addr;
   logic [ADDR_W-1:0] fine_addr;

   assign l1_addr     = {ttb[ADDR_W-1:TTB_LO], va[ADDR_W-1:SEC_LO], 2'b00};
   assign coarse_addr = {desc[ADDR_W-1:CBASE_LO], va[SEC_LO-1:LG_PAGE_LO], 2'b00};
   assign fine_addr   = {desc[ADDR_W-1:FBASE_LO], va[SEC_LO-1:SM_PAGE_LO], 2'b00};
   assign l2_addr     = fine_tbl ? fine_addr : coarse_addr;

   logic unused_bits;
   assign unused_bits = ^{ttb[TTB_LO-1:0], desc[CBASE_LO-1:0], va[SM_PAGE_LO-1:0]};

endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
   import tw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEC_LO     = 20,
   parameter int LG_PAGE_LO = 12,
   parameter int SM_PAGE_LO = 10
) (
   input  logic [ADDR_W-1:0] word,
   input  logic [ADDR_W-1:0] va,
   input  logic              fine_tbl,
   output tw_kind_e          kind,
   output logic [DOM_W-1:0]  dom,
   output logic [ADDR_W-1:0] sec_pa,
   output logic [ADDR_W-1:0] page_pa,
   output logic [AP_W-1:0]   sec_ap,
   output logic [AP_W-1:0]   page_ap,
   output logic              c_bit,
   output logic              b_bit
);
   generate
      if (SEC_AP_LO + AP_W > SEC_LO)
         $error("tw_desc_decode: section permission overlaps the base field");
   endgenerate

   logic [ADDR_W-1:0] lg_pa;
   logic [ADDR_W-1:0] sm_pa;

   assign kind    = tw_kind_e'(word[1:0]);
   assign dom     = word[DOM_LO +: DOM_W];
   assign sec_ap  = word[SEC_AP_LO +: AP_W];
   assign page_ap = word[PG_AP_LO +: AP_W];
   assign c_bit   = word[C_POS];
   assign b_bit   = word[B_POS];

   assign sec_pa  = {word[ADDR_W-1:SEC_LO], va[SEC_LO-1:0]};
   assign lg_pa   = {word[ADDR_W-1:LG_PAGE_LO], va[LG_PAGE_LO-1:0]};
   assign sm_pa   = {word[ADDR_W-1:SM_PAGE_LO], va[SM_PAGE_LO-1:0]};
   assign page_pa = fine_tbl ? sm_pa : lg_pa;

   logic unused_bits;
   assign unused_bits = word[9];

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
   import tw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      mem_req_ready,
   input  logic      mem_rsp_valid,
   input  tw_kind_e  rsp_kind,
   output tw_state_e state,
   output logic      take_req,
   output logic      l1_ret,
   output logic      l2_ret
);
   tw_state_e state_nx;

   assign take_req = (state == ST_IDLE) && req_valid;
   assign l1_ret   = (state == ST_L1_WAIT) && mem_rsp_valid;
   assign l2_ret   = (state == ST_L2_WAIT) && mem_rsp_valid;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:    if (req_valid) state_nx = ST_L1_REQ;
         ST_L1_REQ:  if (mem_req_ready) state_nx = ST_L1_WAIT;
         ST_L1_WAIT: if (mem_rsp_valid)
                        state_nx = (rsp_kind == DK_COARSE || rsp_kind == DK_FINE)
                                   ? ST_L2_REQ : ST_DONE;
         ST_L2_REQ:  if (mem_req_ready) state_nx = ST_L2_WAIT;
         ST_L2_WAIT: if (mem_rsp_valid) state_nx = ST_DONE;
         ST_DONE:    state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assert_l1_fault_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_L1_WAIT && mem_rsp_valid && rsp_kind == DK_FAULT) |=> state == ST_DONE);

   assert_section_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_L1_WAIT && mem_rsp_valid && rsp_kind == DK_SECTION) |=> state == ST_DONE);

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> state == ST_IDLE);

   assert_busy_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_L1_REQ) |=> state != ST_L1_REQ);

endmodule

// File: rtl/tablewalk_unit.sv
module tablewalk_unit
   import tw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEC_LO     = 20,
   parameter int LG_PAGE_LO = 12,
   parameter int SM_PAGE_LO = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [ADDR_W-1:0] req_ttb,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [ADDR_W-1:0] res_paddr,
   output logic [DOM_W-1:0]  res_domain,
   output logic [AP_W-1:0]   res_ap,
   output logic              res_cacheable,
   output logic              res_bufferable,
   output logic [FLT_W-1:0]  res_fault
);
   localparam int TTB_LO = ADDR_W - SEC_LO + 2;

   tw_state_e         state;
   logic              take_req, l1_ret, l2_ret;
   tw_kind_e          kind;
   logic [DOM_W-1:0]  d_dom;
   logic [ADDR_W-1:0] d_sec_pa, d_page_pa;
   logic [AP_W-1:0]   d_sec_ap, d_page_ap;
   logic              d_c, d_b;
   logic [ADDR_W-1:0] l1_addr, l2_addr;

   logic [ADDR_W-1:0] va_q, ttb_q, l2_addr_q;
   logic [DOM_W-1:0]  dom_q;
   logic              fine_q;

   tw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_kind      (kind),
      .state         (state),
      .take_req      (take_req),
      .l1_ret        (l1_ret),
      .l2_ret        (l2_ret)
   );

   tw_addr_gen #(
      .ADDR_W(ADDR_W), .SEC_LO(SEC_LO), .LG_PAGE_LO(LG_PAGE_LO), .SM_PAGE_LO(SM_PAGE_LO)
   ) u_addr (
      .ttb      (ttb_q),
      .va       (va_q),
      .desc     (mem_rsp_data),
      .fine_tbl (kind == DK_FINE),
      .l1_addr  (l1_addr),
      .l2_addr  (l2_addr)
   );

   tw_desc_decode #(
      .ADDR_W(ADDR_W), .SEC_LO(SEC_LO), .LG_PAGE_LO(LG_PAGE_LO), .SM_PAGE_LO(SM_PAGE_LO)
   ) u_dec (
      .word     (mem_rsp_data),
      .va       (va_q),
      .fine_tbl (fine_q),
      .kind     (kind),
      .dom      (d_dom),
      .sec_pa   (d_sec_pa),
      .page_pa  (d_page_pa),
      .sec_ap   (d_sec_ap),
      .page_ap  (d_page_ap),
      .c_bit    (d_c),
      .b_bit    (d_b)
   );

   assign req_ready     = (state == ST_IDLE);
   assign done          = (state == ST_DONE);
   assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
   assign mem_req_addr  = (state == ST_L2_REQ) ? l2_addr_q : l1_addr;

   // walk context
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q      <= '0;
         ttb_q     <= '0;
         l2_addr_q <= '0;
         dom_q     <= '0;
         fine_q    <= 1'b0;
      end else begin
         if (take_req) begin
            va_q  <= req_vaddr;
            ttb_q <= req_ttb;
         end
         if (l1_ret && (kind == DK_COARSE || kind == DK_FINE)) begin
            l2_addr_q <= l2_addr;
            dom_q     <= d_dom;
            fine_q    <= (kind == DK_FINE);
         end
      end
   end

   // result registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_paddr      <= '0;
         res_domain     <= '0;
         res_ap         <= '0;
         res_cacheable  <= 1'b0;
         res_bufferable <= 1'b0;
         res_fault      <= FLT_NONE;
      end else if (l1_ret) begin
         if (kind == DK_SECTION) begin
            res_paddr      <= d_sec_pa;
            res_domain     <= d_dom;
            res_ap         <= d_sec_ap;
            res_cacheable  <= d_c;
            res_bufferable <= d_b;
            res_fault      <= FLT_NONE;
         end else if (kind == DK_FAULT) begin
            res_paddr      <= '0;
            res_domain     <= '0;
            res_ap         <= '0;
            res_cacheable  <= 1'b0;
            res_bufferable <= 1'b0;
            res_fault      <= FLT_L1;
         end
      end else if (l2_ret) begin
         res_domain <= dom_q;
         if (kind == DK_FAULT) begin
            res_paddr      <= '0;
            res_ap         <= '0;
            res_cacheable  <= 1'b0;
            res_bufferable <= 1'b0;
            res_fault      <= FLT_L2;
         end else begin
            res_paddr      <= d_page_pa;
            res_ap         <= d_page_ap;
            res_cacheable  <= d_c;
            res_bufferable <= d_b;
            res_fault      <= FLT_NONE;
         end
      end
   end

   assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_l1_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         (mem_req_addr[1:0] == 2'b00 &&
          mem_req_addr[ADDR_W-1:TTB_LO] == $past(req_ttb[ADDR_W-1:TTB_LO])));

   assert_fault_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault != FLT_NONE) |-> (res_paddr == '0 && res_ap == '0));

   assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (req_ready && !done));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !done));

endmodule

// File: tb/tablewalk_unit_test.sv
module tablewalk_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_ttb = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic [31:0] res_paddr;
   logic [3:0]  res_domain;
   logic [1:0]  res_ap;
   logic        res_cacheable, res_bufferable;
   logic [1:0]  res_fault;

   always #(CLK_PERIOD/2) clk = ~clk;

   tablewalk_unit uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_ttb(req_ttb),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .res_paddr(res_paddr), .res_domain(res_domain),
      .res_ap(res_ap), .res_cacheable(res_cacheable),
      .res_bufferable(res_bufferable), .res_fault(res_fault)
   );

   int total = 0;
   int bad = 0;

   typedef struct packed {
      logic [31:0] va;
      logic [31:0] ttb;
      logic [1:0]  t1;
      logic [1:0]  t2;
   } item_t;

   item_t       work[$];
   logic [31:0] mem [logic [31:0]];

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // plant descriptors for one walk, addresses formed from R2, R6, R7
   task automatic plant(item_t it);
      logic [31:0] a1, d1, a2;
      a1 = {it.ttb[31:14], it.va[31:20], 2'b00};
      d1 = ($urandom() & 32'hFFFF_FFFC) | {30'd0, it.t1};
      mem[a1] = d1;
      if (it.t1 == 2'b01) a2 = {d1[31:10], it.va[19:12], 2'b00};
      else                a2 = {d1[31:12], it.va[19:10], 2'b00};
      if (it.t1[0]) mem[a2] = ($urandom() & 32'hFFFF_FFFC) | {30'd0, it.t2};
   endtask

   // behavioural model: 0 idle,1 l1 req,2 l1 wait,3 l2 req,4 l2 wait,5 done
   int          ph = 0;
   logic [31:0] m_va, m_l1a, m_l2a, m_pa;
   logic [3:0]  m_dom;
   logic [1:0]  m_ap, m_flt;
   logic        m_c, m_b, m_fine;
   int          m_lvl;

   initial begin
      item_t it;
      bit          pend = 0;
      int          cnt = 0;
      int          cyc = 0;
      logic [31:0] pend_addr = '0;
      string       rq;

      for (int t1 = 0; t1 < 4; t1++)
         for (int t2 = 0; t2 < 4; t2++)
            for (int k = 0; k < 3; k++) begin
               it.va  = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : $urandom();
               it.ttb = $urandom();
               it.t1  = t1[1:0];
               it.t2  = t2[1:0];
               work.push_back(it);
            end
      for (int n = 0; n < 250; n++) begin
         it.va  = $urandom();
         it.ttb = $urandom();
         it.t1  = 2'($urandom());
         it.t2  = 2'($urandom());
         work.push_back(it);
      end

      repeat (3) @(negedge clk);
      // reset state, R1
      chk("R1", "reset req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
      chk("R1", "reset done", {31'd0, done}, 32'd0);
      rst_n = 1'b1;

      while (!(work.size() == 0 && ph == 0 && !pend)) begin
         @(negedge clk);
         cyc++;
         if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, 100000);
            break;
         end

         // compare every port with the model
         chk("R1", "req_ready", {31'd0, req_ready}, {31'd0, ph == 0});
         chk("R3", "mem_req_valid", {31'd0, mem_req_valid}, {31'd0, ph == 1 || ph == 3});
         if (ph == 1) chk("R2", "first-level address", mem_req_addr, m_l1a);
         if (ph == 3) chk(m_fine ? "R7" : "R6", "second-level address", mem_req_addr, m_l2a);
         chk("R11", "done", {31'd0, done}, {31'd0, ph == 5});
         if (ph == 5) begin
            if (m_flt == 2'd1)      rq = "R4";
            else if (m_flt == 2'd2) rq = "R8";
            else if (m_lvl == 1)    rq = "R5";
            else if (m_fine)        rq = "R10";
            else                    rq = "R9";
            chk(rq, "fault", {30'd0, res_fault}, {30'd0, m_flt});
            chk(rq, "paddr", res_paddr, m_pa);
            chk(rq, "domain", {28'd0, res_domain}, {28'd0, m_dom});
            chk(rq, "ap", {30'd0, res_ap}, {30'd0, m_ap});
            chk(rq, "c/b", {30'd0, res_cacheable, res_bufferable}, {30'd0, m_c, m_b});
         end

         // memory responder
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = $urandom();
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd(pend_addr);
               pend = 0;
            end else cnt--;
         end
         mem_req_ready = ($urandom() % 3) != 0;
         if (mem_req_valid && mem_req_ready) begin
            pend = 1;
            cnt = $urandom() % 3;
            pend_addr = mem_req_addr;
         end

         // requester: junk while busy must be ignored (R1)
         req_valid = 1'b0;
         req_vaddr = $urandom();
         req_ttb   = $urandom();
         if (ph == 0) begin
            if (work.size() > 0 && ($urandom() % 2) == 0) begin
               it = work.pop_front();
               plant(it);
               req_valid = 1'b1;
               req_vaddr = it.va;
               req_ttb   = it.ttb;
            end
         end else req_valid = 1'($urandom());

         // model step for the coming edge
         case (ph)
            0: if (req_valid) begin
                  m_va  = req_vaddr;
                  m_l1a = {req_ttb[31:14], req_vaddr[31:20], 2'b00};
                  ph = 1;
               end
            1: if (mem_req_ready) ph = 2;
            2: if (mem_rsp_valid) begin
                  case (mem_rsp_data[1:0])
                     2'b00: begin
                        m_flt = 2'd1; m_pa = '0; m_dom = '0; m_ap = '0;
                        m_c = 0; m_b = 0; m_lvl = 1; ph = 5;
                     end
                     2'b10: begin
                        m_flt = 2'd0; m_lvl = 1;
                        m_pa  = {mem_rsp_data[31:20], m_va[19:0]};
                        m_dom = mem_rsp_data[8:5];
                        m_ap  = mem_rsp_data[11:10];
                        m_c   = mem_rsp_data[3];
                        m_b   = mem_rsp_data[2];
                        ph = 5;
                     end
                     2'b01: begin
                        m_fine = 0; m_dom = mem_rsp_data[8:5];
                        m_l2a = {mem_rsp_data[31:10], m_va[19:12], 2'b00};
                        ph = 3;
                     end
                     default: begin
                        m_fine = 1; m_dom = mem_rsp_data[8:5];
                        m_l2a = {mem_rsp_data[31:12], m_va[19:10], 2'b00};
                        ph = 3;
                     end
                  endcase
               end
            3: if (mem_req_ready) ph = 4;
            4: if (mem_rsp_valid) begin
                  m_lvl = 2;
                  if (mem_rsp_data[1:0] == 2'b00) begin
                     m_flt = 2'd2; m_pa = '0; m_ap = '0; m_c = 0; m_b = 0;
                  end else begin
                     m_flt = 2'd0;
                     m_pa  = m_fine ? {mem_rsp_data[31:10], m_va[9:0]}
                                    : {mem_rsp_data[31:12], m_va[11:0]};
                     m_ap  = mem_rsp_data[5:4];
                     m_c   = mem_rsp_data[3];
                     m_b   = mem_rsp_data[2];
                  end
                  ph = 5;
               end
            default: ph = 0;
         endcase
      end

      req_valid = 1'b0;
      mem_rsp_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "final idle", {31'd0, req_ready}, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule